// File: doc/BRIEF.md
# Packed Element Interleave Unit

This datapath builds a 64-bit result by weaving together elements drawn from one half of each of two 64-bit operands. Operand A plays the destination role and operand B the source role. A half select decides whether the upper or the lower 32 bits of each operand are kept. The other half is discarded. A granularity code sets the element size.

The retained halves are merged pair by pair, starting from the least significant element. In every pair, the element from B takes the more significant slot and the element from A takes the less significant slot.

One operation is accepted on any cycle where `in_valid` is high. Its result appears on a registered output, flagged by `out_valid`, one cycle later. Operations may be issued on consecutive cycles, and each select may change from one operation to the next. When no operation is accepted, the output data keeps its last value.

Top module: `elem_interleave_unit`

## Requirements
- R1: While `rst` is high at a rising clock edge, `out_valid` is 0 after that edge.
- R2: `out_valid` is 1 exactly in the cycle that follows a cycle with `in_valid` high, and 0 otherwise. Each result corresponds to the operation accepted one cycle earlier, in issue order.
- R3: With `sel_high` = 1, only bits 63..32 of A and of B contribute to the result. The lowest result byte is A[39:32] and the highest result byte is B[63:56].
- R4: With `sel_high` = 0, only bits 31..0 of A and of B contribute to the result. The lowest result byte is A[7:0] and the highest result byte is B[31:24].
- R5: Granularity code 0 selects byte elements. Result byte 2k is byte k of the kept A half, and result byte 2k+1 is byte k of the kept B half, for k = 0..3. With A=0x7A6A5A4A3A2A1A0A and B=0x7B6B5B4B3B2B1B0B, the high form gives 0x7B7A6B6A5B5A4B4A and the low form gives 0x3B3A2B2A1B1A0B0A.
- R6: Granularity code 1 selects 16-bit elements, interleaved in the same order. On the R5 inputs, the high form gives 0x7B6B7A6A5B4B5A4A and the low form gives 0x3B2B3A2A1B0B1A0A.
- R7: Granularity code 2 selects 32-bit elements, interleaved in the same order. On the R5 inputs, the high form gives 0x7B6B5B4B7A6A5A4A and the low form gives 0x3B2B1B0B3A2A1A0A.
- R8: Granularity code 3 treats each kept half as one element. The result is the kept B half in bits 63..32 and the kept A half in bits 31..0.
- R9: In a cycle following one with `in_valid` low, `out_data` is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Accept an operation this cycle |
| opnd_a | input | 64 | Destination-role operand A |
| opnd_b | input | 64 | Source-role operand B |
| sel_high | input | 1 | 1 keeps upper halves, 0 keeps lower halves |
| sel_gran | input | 2 | Element size: 0 byte, 1 word, 2 doubleword, 3 whole half |
| out_valid | output | 1 | Result valid |
| out_data | output | 64 | Interleaved result |

## Verification
Two things can fall in the same cycle. A new operation can be accepted while the previous result is being presented, and the selects can change at that same boundary. The bench provokes this by issuing bursts of back-to-back operations whose half select and granularity are drawn at random per item, mixed with idle gaps. A queue-based scoreboard pairs every presented result with its own issued operation in order. It flags any result that arrives without an expectation, or that carries the selects of a neighbouring operation. After every idle stretch, the held output is compared against the last result.

// File: rtl/eiu_pkg.sv
package eiu_pkg;
  typedef enum logic [1:0] {
    GR_BYTE  = 2'd0,
    GR_WORD  = 2'd1,
    GR_DWORD = 2'd2,
    GR_HALF  = 2'd3
  } gran_e;

  localparam int unsigned GRAN_COUNT = 4;
  localparam int unsigned BASE_ELEM_W = 8;
endpackage

// File: rtl/eiu_half_select.sv
module eiu_half_select #(
  parameter int unsigned DATA_W = 64
) (
  input  logic [DATA_W-1:0]   opnd_a,
  input  logic [DATA_W-1:0]   opnd_b,
  input  logic                sel_high,
  output logic [DATA_W/2-1:0] a_half,
  output logic [DATA_W/2-1:0] b_half
);
  localparam int unsigned HALF_W = DATA_W / 2;

  always_comb begin
    if (sel_high) begin
      a_half = opnd_a[DATA_W-1:HALF_W];
      b_half = opnd_b[DATA_W-1:HALF_W];
    end else begin
      a_half = opnd_a[HALF_W-1:0];
      b_half = opnd_b[HALF_W-1:0];
    end
  end
endmodule

// File: rtl/eiu_lane_weave.sv
module eiu_lane_weave #(
  parameter int unsigned HALF_W = 32,
  parameter int unsigned ELEM_W = 8
) (
  input  logic [HALF_W-1:0]   a_half,
  input  logic [HALF_W-1:0]   b_half,
  output logic [2*HALF_W-1:0] woven
);
  localparam int unsigned PAIRS = HALF_W / ELEM_W;

  for (genvar p = 0; p < PAIRS; p++) begin : g_pair
    assign woven[(2*p)*ELEM_W   +: ELEM_W] = a_half[p*ELEM_W +: ELEM_W];
    assign woven[(2*p+1)*ELEM_W +: ELEM_W] = b_half[p*ELEM_W +: ELEM_W];
  end
endmodule

// File: rtl/eiu_weave_mux.sv
module eiu_weave_mux
  import eiu_pkg::*;
#(
  parameter int unsigned DATA_W = 64
) (
  input  logic [DATA_W/2-1:0] a_half,
  input  logic [DATA_W/2-1:0] b_half,
  input  logic [1:0]          sel_gran,
  output logic [DATA_W-1:0]   woven
);
  localparam int unsigned HALF_W = DATA_W / 2;

  logic [DATA_W-1:0] cand [GRAN_COUNT];

  for (genvar g = 0; g < GRAN_COUNT; g++) begin : g_gran
    localparam int unsigned EW = (g == GRAN_COUNT-1) ? HALF_W : (BASE_ELEM_W << g);
    eiu_lane_weave #(
      .HALF_W (HALF_W),
      .ELEM_W (EW)
    ) u_weave (
      .a_half (a_half),
      .b_half (b_half),
      .woven  (cand[g])
    );
  end

  always_comb begin
    woven = cand[sel_gran];
  end
endmodule

// File: rtl/eiu_result_reg.sv
module eiu_result_reg #(
  parameter int unsigned DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] next_data,
  output logic              q_valid,
  output logic [DATA_W-1:0] q_data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q_valid <= 1'b0;
    end else begin
      q_valid <= load;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q_data <= '0;
    end else if (load) begin
      q_data <= next_data;
    end
  end
endmodule

// File: rtl/elem_interleave_unit.sv
module elem_interleave_unit #(
  parameter int unsigned DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  input  logic              sel_high,
  input  logic [1:0]        sel_gran,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data
);
  localparam int unsigned HALF_W = DATA_W / 2;

  logic [HALF_W-1:0] a_half;
  logic [HALF_W-1:0] b_half;
  logic [DATA_W-1:0] woven;

  eiu_half_select #(.DATA_W(DATA_W)) u_half (
    .opnd_a   (opnd_a),
    .opnd_b   (opnd_b),
    .sel_high (sel_high),
    .a_half   (a_half),
    .b_half   (b_half)
  );

  eiu_weave_mux #(.DATA_W(DATA_W)) u_mux (
    .a_half   (a_half),
    .b_half   (b_half),
    .sel_gran (sel_gran),
    .woven    (woven)
  );

  eiu_result_reg #(.DATA_W(DATA_W)) u_reg (
    .clk       (clk),
    .rst       (rst),
    .load      (in_valid),
    .next_data (woven),
    .q_valid   (out_valid),
    .q_data    (out_data)
  );
endmodule

// File: rtl/eiu_checker.sv
module eiu_checker #(
  parameter int unsigned DATA_W = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [DATA_W-1:0] opnd_a,
  input logic [DATA_W-1:0] opnd_b,
  input logic              sel_high,
  input logic [1:0]        sel_gran,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_data
);
  localparam int unsigned HALF_W = DATA_W / 2;

  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> !out_valid); // R1
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst) in_valid |=> out_valid); // R2
  AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (rst) !in_valid |=> !out_valid); // R2
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst) !in_valid |=> $stable(out_data)); // R9
  AST_HIGH_EDGES: assert property (@(posedge clk) disable iff (rst)
    (in_valid && sel_high) |=> (out_data[7:0] == $past(opnd_a[HALF_W +: 8])) &&
                               (out_data[DATA_W-1 -: 8] == $past(opnd_b[DATA_W-1 -: 8]))); // R3
  AST_LOW_EDGES: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !sel_high) |=> (out_data[7:0] == $past(opnd_a[7:0])) &&
                                (out_data[DATA_W-1 -: 8] == $past(opnd_b[HALF_W-1 -: 8]))); // R4
  AST_WHOLE_HALF: assert property (@(posedge clk) disable iff (rst)
    (in_valid && sel_gran == 2'd3 && !sel_high) |=>
      (out_data == {$past(opnd_b[HALF_W-1:0]), $past(opnd_a[HALF_W-1:0])})); // R8
endmodule

bind elem_interleave_unit eiu_checker #(.DATA_W(DATA_W)) u_eiu_checker (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .opnd_a    (opnd_a),
  .opnd_b    (opnd_b),
  .sel_high  (sel_high),
  .sel_gran  (sel_gran),
  .out_valid (out_valid),
  .out_data  (out_data)
);

// File: tb/test_elem_interleave_unit.sv
`timescale 1ns/1ps
module test_elem_interleave_unit;
  typedef struct {
    logic [63:0] data;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [63:0] opnd_a = '0;
  logic [63:0] opnd_b = '0;
  logic        sel_high = 1'b0;
  logic [1:0]  sel_gran = 2'd0;
  logic        out_valid;
  logic [63:0] out_data;

  int          n_checks = 0;
  int          n_fail = 0;
  exp_t        sb[$];
  logic [63:0] last_exp = '0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  elem_interleave_unit #(.DATA_W(64)) i_elem_interleave_unit (
    .clk (clk), .rst (rst), .in_valid (in_valid),
    .opnd_a (opnd_a), .opnd_b (opnd_b),
    .sel_high (sel_high), .sel_gran (sel_gran),
    .out_valid (out_valid), .out_data (out_data)
  );

  function automatic logic [63:0] model(input logic [63:0] a, input logic [63:0] b,
                                        input logic hi, input logic [1:0] g);
    logic [31:0] ah, bh;
    logic [63:0] r;
    int ew;
    ah = hi ? a[63:32] : a[31:0];
    bh = hi ? b[63:32] : b[31:0];
    ew = (g == 2'd3) ? 32 : (8 << g);
    r = '0;
    for (int k = 0; k < 64 / ew; k++) begin
      for (int j = 0; j < ew; j++) begin
        r[k*ew + j] = (k % 2 == 1) ? bh[(k/2)*ew + j] : ah[(k/2)*ew + j];
      end
    end
    return r;
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [63:0] a, input logic [63:0] b, input logic hi,
                       input logic [1:0] g, input logic [63:0] exp, input string tag);
    exp_t e;
    @(negedge clk);
    opnd_a = a; opnd_b = b; sel_high = hi; sel_gran = g; in_valid = 1'b1;
    e.data = exp; e.tag = tag;
    sb.push_back(e);
    last_exp = exp;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      opnd_a = {$urandom, $urandom}; opnd_b = {$urandom, $urandom};
      sel_high = 1'($urandom); sel_gran = 2'($urandom);
    end
  endtask

  // monitor: samples 1 ns after each rising edge
  always @(posedge clk) begin
    #1;
    if (!rst && !done) begin
      if (out_valid) begin
        if (sb.size() == 0) begin
          n_checks++; n_fail++;
          $display("FAIL R2 actual=unexpected valid expected=no valid");
        end else begin
          exp_t e;
          e = sb.pop_front();
          check(e.tag, out_data, e.data);
        end
      end else if (sb.size() != 0) begin
        n_checks++; n_fail++;
        $display("FAIL R2 actual=no valid expected=result %h", sb[0].data);
        void'(sb.pop_front());
      end
    end
  end

  initial begin
    #400000;
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=hung expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  localparam logic [63:0] VA = 64'h7A6A5A4A3A2A1A0A;
  localparam logic [63:0] VB = 64'h7B6B5B4B3B2B1B0B;

  initial begin
    in_valid = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset valid", {63'd0, out_valid}, 64'd0);
    @(negedge clk);
    in_valid = 1'b0; rst = 1'b0;
    @(posedge clk); #1;
    check("R1 valid after reset", {63'd0, out_valid}, 64'd0);

    issue(VA, VB, 1'b1, 2'd0, 64'h7B7A6B6A5B5A4B4A, "R5 R3 high byte");
    issue(VA, VB, 1'b1, 2'd1, 64'h7B6B7A6A5B4B5A4A, "R6 R3 high word");
    issue(VA, VB, 1'b1, 2'd2, 64'h7B6B5B4B7A6A5A4A, "R7 R3 high dword");
    issue(VA, VB, 1'b0, 2'd0, 64'h3B3A2B2A1B1A0B0A, "R5 R4 low byte");
    issue(VA, VB, 1'b0, 2'd1, 64'h3B2B3A2A1B0B1A0A, "R6 R4 low word");
    issue(VA, VB, 1'b0, 2'd2, 64'h3B2B1B0B3A2A1A0A, "R7 R4 low dword");
    issue(VA, VB, 1'b1, 2'd3, 64'h7B6B5B4B7A6A5A4A, "R8 high half");
    issue(VA, VB, 1'b0, 2'd3, 64'h3B2B1B0B3A2A1A0A, "R8 low half");
    idle(4);
    check("R9 hold after idle", out_data, last_exp);
    check("R2 idle valid", {63'd0, out_valid}, 64'd0);

    for (int n = 0; n < 300; n++) begin
      logic [63:0] a, b;
      logic hi;
      logic [1:0] g;
      a = {$urandom, $urandom}; b = {$urandom, $urandom};
      hi = 1'($urandom); g = 2'($urandom);
      issue(a, b, hi, g, model(a, b, hi, g), "R10 R2 random stream");
      if ($urandom_range(0, 5) == 0) begin
        idle($urandom_range(1, 3));
        check("R9 hold in stream", out_data, last_exp);
      end
    end
    idle(3);
    check("R9 final hold", out_data, last_exp);
    check("R2 queue drained", 64'(sb.size()), 64'd0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule